// File: doc/BRIEF.md
# Dual-Mode Digital Phase Detector

This block compares a reference input with a feedback input and reports a one-bit phase error for the loop filter that follows it. Both inputs come from outside the system clock domain, so each is first brought into that domain. The block then evaluates two detectors side by side. The first is an exclusive-OR detector with a gain of 4. It reads zero error when the inputs are a quarter cycle apart. The second is a set/reset detector with a gain of 2, which changes state only on rising edges. It reads zero error when the inputs are half a cycle apart.

A select input picks which detector drives the main error output. Both raw detector results are also exported, so a downstream up/down counter or a monitor can watch either one. Both detectors give a square wave of 50% duty at their zero-error point. At the edge of their linear range they hold constantly high or constantly low.

Top module: `phase_det_dual`

## Requirements
- R1: While `rst` is high, and in the cycle after the clock edge at which it was sampled high, `xor_err`, `edge_err` and `phase_err` are all 0. Reset also clears the synchronizers and the edge history.
- R2: `xor_err` equals `ref_in` XOR `fb_in` as sampled SYNC_STAGES+1 clock edges earlier. With the default of 2 this is a latency of 3 edges, and the output does not change after only 2 edges.
- R3: A rising edge on the synchronized `ref_in`, without a rising edge on `fb_in` in the same cycle, sets `edge_err` to 1. This appears with the same latency as R2.
- R4: A rising edge on the synchronized `fb_in`, without a rising edge on `ref_in` in the same cycle, clears `edge_err` to 0.
- R5: When both inputs rise in the same cycle, `edge_err` keeps its previous value.
- R6: Falling edges and steady levels on either input leave `edge_err` unchanged.
- R7: The value of `mode_sel` sampled at a clock edge decides the source of `phase_err` after that edge. A value of 0 selects the exclusive-OR result and a value of 1 selects the edge-controlled result. `phase_err` then equals `xor_err` or `edge_err` respectively, in the same cycle.
- R8: Take 16-cycle square waves of 50% duty. With `fb_in` lagging by a quarter period, `xor_err` is high 8 of every 16 cycles. With `fb_in` lagging by half a period, `edge_err` is high 8 of every 16 cycles.
- R9: At the limits of its range, the exclusive-OR output is held at a constant level. It is constantly low for in-phase inputs (0 of 16 cycles high) and constantly high for inputs in antiphase (16 of 16).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Reference signal, asynchronous |
| fb_in | input | 1 | Feedback signal, asynchronous |
| mode_sel | input | 1 | 0 selects the exclusive-OR detector, 1 selects the edge-controlled detector |
| xor_err | output | 1 | Registered exclusive-OR detector output |
| edge_err | output | 1 | Registered edge-controlled detector output |
| phase_err | output | 1 | Registered output of the selected detector |

## Verification
The bench builds the block with its default of two synchronizer stages, which fixes the latency at three edges. This lets the stimulus table hold each vector for four cycles and still see a settled result. A directed probe then checks that the output has not yet moved after two edges and has moved after three. The 16-cycle square waves make the quarter-period and half-period offsets whole numbers of clocks. Duty can therefore be counted exactly, for the zero-error points and for both limits of the exclusive-OR range.

// File: rtl/phdet_pkg.sv
package phdet_pkg;
  typedef enum logic {
    DET_XOR  = 1'b0,
    DET_EDGE = 1'b1
  } det_sel_e;

  localparam int NUM_CH = 2;
  localparam int CH_REF = 0;
  localparam int CH_FB  = 1;
endpackage

// File: rtl/phdet_sync.sv
module phdet_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-2:0], din};
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/phdet_rise.sv
module phdet_rise (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= din;
  end

  assign rise = din & ~prev_q;
endmodule

// File: rtl/phdet_srcore.sv
module phdet_srcore (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q_next,
  output logic q
);
  always_comb begin
    q_next = q;
    if (set_i && !clr_i)      q_next = 1'b1;
    else if (clr_i && !set_i) q_next = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= q_next;
  end
endmodule

// File: rtl/phase_det_dual.sv
module phase_det_dual
  import phdet_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_in,
  input  logic fb_in,
  input  logic mode_sel,
  output logic xor_err,
  output logic edge_err,
  output logic phase_err
);
  logic [NUM_CH-1:0] raw_in;
  logic [NUM_CH-1:0] syn;
  logic [NUM_CH-1:0] rise;
  logic              xor_next;
  logic              edge_next;
  logic              xor_q;
  logic              sel_q;
  det_sel_e          sel;

  assign raw_in[CH_REF] = ref_in;
  assign raw_in[CH_FB]  = fb_in;
  assign sel            = det_sel_e'(mode_sel);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    phdet_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst  (rst),
      .din  (raw_in[ch]),
      .dout (syn[ch])
    );
    phdet_rise u_rise (
      .clk  (clk),
      .rst  (rst),
      .din  (syn[ch]),
      .rise (rise[ch])
    );
  end

  assign xor_next = syn[CH_REF] ^ syn[CH_FB];

  phdet_srcore u_sr (
    .clk    (clk),
    .rst    (rst),
    .set_i  (rise[CH_REF]),
    .clr_i  (rise[CH_FB]),
    .q_next (edge_next),
    .q      (edge_err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      xor_q <= 1'b0;
      sel_q <= 1'b0;
    end else begin
      xor_q <= xor_next;
      sel_q <= (sel == DET_EDGE) ? edge_next : xor_next;
    end
  end

  assign xor_err   = xor_q;
  assign phase_err = sel_q;
endmodule

// File: rtl/phdet_chk.sv
module phdet_chk #(
  parameter int SYNC_STAGES = 2
) (
  input logic clk,
  input logic rst,
  input logic ref_in,
  input logic fb_in,
  input logic mode_sel,
  input logic xor_err,
  input logic edge_err,
  input logic phase_err
);
  localparam int LAT  = SYNC_STAGES + 1;
  localparam int CW   = $clog2(LAT + 2);

  logic [LAT:0]  ref_dl, fb_dl;
  logic [CW-1:0] age;
  logic          warm, mode_d, edge_d;
  logic          set_seen, clr_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_dl <= '0;
      fb_dl  <= '0;
      age    <= '0;
      mode_d <= 1'b0;
      edge_d <= 1'b0;
    end else begin
      ref_dl <= {ref_dl[LAT-1:0], ref_in};
      fb_dl  <= {fb_dl[LAT-1:0], fb_in};
      if (age != CW'(LAT + 1)) age <= age + 1'b1;
      mode_d <= mode_sel;
      edge_d <= edge_err;
    end
  end

  assign warm     = (age == CW'(LAT + 1));
  assign set_seen = ref_dl[LAT-1] & ~ref_dl[LAT];
  assign clr_seen = fb_dl[LAT-1] & ~fb_dl[LAT];

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!xor_err && !edge_err && !phase_err)); // R1

  AST_XOR_LATENCY: assert property (@(posedge clk) disable iff (rst)
    warm |-> (xor_err == (ref_dl[LAT-1] ^ fb_dl[LAT-1]))); // R2

  AST_EDGE_SET: assert property (@(posedge clk) disable iff (rst)
    (warm && set_seen && !clr_seen) |-> edge_err); // R3

  AST_EDGE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (warm && clr_seen && !set_seen) |-> !edge_err); // R4

  AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (warm && (set_seen == clr_seen)) |-> (edge_err == edge_d)); // R5

  AST_SEL_ROUTE: assert property (@(posedge clk) disable iff (rst)
    warm |-> (phase_err == (mode_d ? edge_err : xor_err))); // R7
endmodule

bind phase_det_dual phdet_chk #(.SYNC_STAGES(SYNC_STAGES)) u_phdet_chk (
  .clk       (clk),
  .rst       (rst),
  .ref_in    (ref_in),
  .fb_in     (fb_in),
  .mode_sel  (mode_sel),
  .xor_err   (xor_err),
  .edge_err  (edge_err),
  .phase_err (phase_err)
);

// File: tb/test_phase_det_dual.sv
module test_phase_det_dual;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_in = 1'b0;
  logic fb_in = 1'b0;
  logic mode_sel = 1'b0;
  logic xor_err, edge_err, phase_err;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  phase_det_dual #(.SYNC_STAGES(2)) i_phase_det_dual (
    .clk       (clk),
    .rst       (rst),
    .ref_in    (ref_in),
    .fb_in     (fb_in),
    .mode_sel  (mode_sel),
    .xor_err   (xor_err),
    .edge_err  (edge_err),
    .phase_err (phase_err)
  );

  // {ref, fb, mode, exp_xor, exp_edge, exp_sel}; each row held 4 cycles
  localparam logic [5:0] TBL [0:13] = '{
    6'b000_000, // idle
    6'b100_111, // R3 ref rise sets
    6'b111_000, // R4 fb rise clears
    6'b011_100, // R6 ref fall keeps
    6'b111_011, // R3 ref rise sets
    6'b100_111, // R6 fb fall keeps
    6'b001_011, // R6 ref fall keeps
    6'b111_011, // R5 both rise keep 1
    6'b000_010, // R7 mode 0 routes xor
    6'b011_100, // R4 fb rise clears
    6'b101_111, // R3 ref rise with fb fall
    6'b110_000, // R4 fb rise clears
    6'b001_000, // idle, mode 1
    6'b111_000  // R5 both rise keep 0
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic wave(input int offset, output int nx, output int ne, output int np);
    nx = 0; ne = 0; np = 0;
    for (int c = 0; c < 96; c++) begin
      @(negedge clk);
      if (c >= 64 && c < 80) begin
        nx += int'(xor_err);
        ne += int'(edge_err);
        np += int'(phase_err);
      end
      ref_in = ((c % 16) < 8);
      fb_in  = (((c - offset + 16) % 16) < 8);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    int nx, ne, np;
    repeat (3) @(negedge clk);
    chk("R1 xor in reset", int'(xor_err), 0);
    chk("R1 edge in reset", int'(edge_err), 0);
    chk("R1 sel in reset", int'(phase_err), 0);
    rst = 1'b0;

    for (int i = 0; i < 14; i++) begin
      @(negedge clk);
      {ref_in, fb_in, mode_sel} = TBL[i][5:3];
      repeat (4) @(negedge clk);
      chk($sformatf("R2 xor row %0d", i), int'(xor_err), int'(TBL[i][2]));
      chk($sformatf("R3/R4/R5/R6 edge row %0d", i), int'(edge_err), int'(TBL[i][1]));
      chk($sformatf("R7 sel row %0d", i), int'(phase_err), int'(TBL[i][0]));
    end

    // R2 latency probe
    @(negedge clk);
    ref_in = 1'b0; fb_in = 1'b0; mode_sel = 1'b0;
    repeat (4) @(negedge clk);
    ref_in = 1'b1;
    repeat (2) @(negedge clk);
    chk("R2 not yet after 2 edges", int'(xor_err), 0);
    @(negedge clk);
    chk("R2 visible after 3 edges", int'(xor_err), 1);
    chk("R3 edge set after 3 edges", int'(edge_err), 1);

    // R1 reset clears a set state
    rst = 1'b1;
    @(negedge clk);
    chk("R1 xor cleared", int'(xor_err), 0);
    chk("R1 edge cleared", int'(edge_err), 0);
    chk("R1 sel cleared", int'(phase_err), 0);
    ref_in = 1'b0;
    @(negedge clk);
    rst = 1'b0;

    // R8 quarter offset, xor selected
    mode_sel = 1'b0;
    wave(4, nx, ne, np);
    chk("R8 xor duty quarter offset", nx, 8);
    chk("R7 sel follows xor in wave", np, nx);
    // R8 half offset, edge selected
    mode_sel = 1'b1;
    wave(8, nx, ne, np);
    chk("R8 edge duty half offset", ne, 8);
    chk("R9 xor high limit antiphase", nx, 16);
    chk("R7 sel follows edge in wave", np, ne);
    // R9 in phase
    wave(0, nx, ne, np);
    chk("R9 xor low limit in phase", nx, 0);

    done = 1'b1;
    summary();
  end
endmodule